// File: doc/BRIEF.md
# Integer ALU With Condition Codes

This block is the integer execute stage of a processor core for the non-shifting, non-multiplying operations. Each cycle it takes a first source operand and a second operand, which is either a second register value or a sign-extended short immediate. From these it produces a 32-bit result combinationally. The operations are add, add with carry-in, subtract, subtract with borrow-in, and six bitwise operations: AND, OR, XOR, AND with inverted operand, OR with inverted operand, and inverted XOR.

When the set-flags strobe is high, the block records four condition bits in a flag register at the next rising clock edge: negative (N), zero (Z), signed overflow (V) and carry/borrow (C). When the strobe is low, the register keeps its old value.

The carry used by the carry-in operations comes from an 8-bit condition input that carries two flag nibbles, a narrow (32-bit) view and a wide (64-bit) view. A select pin chooses which nibble supplies the carry.

Top module: `cc_int_alu`

## Requirements
- R1: Arithmetic opcodes produce a W-bit wrap-around result. 0 is op1+op2, 1 is op1+op2+cin, 2 is op1-op2 and 3 is op1-op2-cin.
- R2: Bitwise opcodes produce these results: 4 is op1&op2, 5 is op1|op2, 6 is op1^op2, 7 is op1&~op2, 8 is op1|~op2, 9 is ~(op1^op2).
- R3: op2 is rs2 when use_imm is 0. When use_imm is 1, op2 is the 13-bit imm sign-extended to W bits.
- R4: For opcodes 0 and 1, the next flags have C equal to the unsigned carry out of the full sum. V is set when both operands have the same sign and the sum's sign differs from it.
- R5: For opcode 2, the next flags have C set exactly when op1 < op2 as unsigned values. V is set when the operands differ in sign and the result's sign differs from op1's sign.
- R6: For opcode 3, C is set when op1 < op2 (unsigned), and also when op1 equals op2 and cin is 1. V uses the R5 rule on the final result.
- R7: Flag nibbles are laid out {N,Z,V,C} at bits 3..0. cc_in[3:0] is the narrow view and cc_in[7:4] is the wide view. cin is cc_in[0] when cc_wide is 0 and cc_in[4] when cc_wide is 1.
- R8: In every flag update, N is result bit W-1 and Z is 1 exactly when the result is zero. For bitwise opcodes, V and C are 0.
- R9: At a rising edge with set_flags 0, flags keep their value. With set_flags 1, flags take the values computed for the current inputs.
- R10: While rst_n is low, flags are 4'b0000.
- R11: Opcodes 10 to 15 give result 0. When they are recorded, the flags are 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Record flags at the next rising edge |
| use_imm | input | 1 | Select immediate as second operand |
| rs1 | input | W | First operand |
| rs2 | input | W | Register second operand |
| imm | input | IMM_W | Immediate, sign-extended before use |
| cc_in | input | 8 | Incoming flags, wide view high nibble, narrow view low |
| cc_wide | input | 1 | Take carry-in from the wide view |
| result | output | W | Operation result |
| flags | output | 4 | Registered {N,Z,V,C} |

## Verification
The bench builds the block with its defaults, W of 32 and IMM_W of 13. With these widths, the sign boundaries (0x7FFFFFFF, 0x80000000) and the all-ones patterns can be hit directly, where carry and overflow separate. The 13-bit immediate lets a negative value such as -1 reach every bit of op2 through sign extension. This exercises the borrow-in equality case with op2 = 0xFFFFFFFF. Carry-in is driven with opposite bits in the two cc_in nibbles, so a wrong view choice changes the result.

// File: rtl/cc_int_alu.sv
module cc_int_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             use_imm,
  input  logic [W-1:0]     rs1,
  input  logic [W-1:0]     rs2,
  input  logic [IMM_W-1:0] imm,
  input  logic [7:0]       cc_in,
  input  logic             cc_wide,
  output logic [W-1:0]     result,
  output logic [3:0]       flags
);
  localparam int MSB = W - 1;
  localparam int EXT = W - IMM_W;

  logic [W-1:0] op2, sum, dif;
  logic         cin, use_c, n_f, z_f, v_f, c_f, is_logic;

  assign op2   = use_imm ? {{EXT{imm[IMM_W-1]}}, imm} : rs2;
  assign cin   = cc_wide ? cc_in[4] : cc_in[0];
  assign use_c = (opcode == 4'd1) || (opcode == 4'd3);
  assign sum   = rs1 + op2 + W'(use_c & cin);
  assign dif   = rs1 - op2 - W'(use_c & cin);
  assign is_logic = (opcode >= 4'd4);

  always_comb begin
    case (opcode)
      4'd0, 4'd1: result = sum;
      4'd2, 4'd3: result = dif;
      4'd4:       result = rs1 & op2;
      4'd5:       result = rs1 | op2;
      4'd6:       result = rs1 ^ op2;
      4'd7:       result = rs1 & ~op2;
      4'd8:       result = rs1 | ~op2;
      4'd9:       result = ~(rs1 ^ op2);
      default:    result = '0;
    endcase
  end

  assign n_f = result[MSB];
  assign z_f = (result == '0);

  always_comb begin
    v_f = 1'b0;
    c_f = 1'b0;
    if (opcode <= 4'd1) begin
      v_f = (~rs1[MSB] & ~op2[MSB] & sum[MSB]) | (rs1[MSB] & op2[MSB] & ~sum[MSB]);
      c_f = (rs1[MSB] & op2[MSB]) | (~sum[MSB] & (rs1[MSB] | op2[MSB]));
    end else if (!is_logic) begin
      v_f = (~rs1[MSB] & op2[MSB] & dif[MSB]) | (rs1[MSB] & ~op2[MSB] & ~dif[MSB]);
      c_f = (rs1 < op2) | ((opcode == 4'd3) & (rs1 == op2) & cin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= 4'b0000;
    else if (set_flags) flags <= {n_f, z_f, v_f, c_f};
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags));
  a_r8_logic_vc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && opcode >= 4'd4) |=> (flags[1:0] == 2'b00));
  a_r8_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flags[3] == $past(result[MSB]) && flags[2] == ($past(result) == '0)));
  a_r4_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && opcode == 4'd0) |=> (flags[0] == $past(({1'b0, rs1} + {1'b0, op2}) >> W)));
  a_r6_equal_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && opcode == 4'd3 && rs1 == op2) |=> (flags[0] == $past(cin)));
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 4'd10) |-> (result == '0));
endmodule

// File: tb/tb_cc_int_alu.sv
module tb_cc_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic        use_imm = 1'b0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic [12:0] imm = '0;
  logic [7:0]  cc_in = '0;
  logic        cc_wide = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0, fails = 0;
  logic [3:0] model_flags = 4'b0000;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  cc_int_alu dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .set_flags(set_flags),
    .use_imm(use_imm), .rs1(rs1), .rs2(rs2), .imm(imm), .cc_in(cc_in),
    .cc_wide(cc_wide), .result(result), .flags(flags));

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [3:0] op, input logic sf,
                       input logic ui, input logic [31:0] a, input logic [31:0] b,
                       input logic [12:0] im, input logic [7:0] cc, input logic wide);
    logic [31:0] o2, r;
    logic [32:0] t;
    logic c, v, ci;
    item_t it;
    @(negedge clk);
    opcode = op; set_flags = sf; use_imm = ui; rs1 = a; rs2 = b; imm = im;
    cc_in = cc; cc_wide = wide;
    o2 = ui ? {{19{im[12]}}, im} : b;
    ci = wide ? cc[4] : cc[0];
    c = 1'b0; v = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        t = {1'b0, a} + {1'b0, o2} + ((op == 4'd1) ? 33'(ci) : 33'd0);
        r = t[31:0]; c = t[32];
        v = (a[31] == o2[31]) && (r[31] != a[31]);
      end
      4'd2, 4'd3: begin
        t = {1'b0, a} - {1'b0, o2} - ((op == 4'd3) ? 33'(ci) : 33'd0);
        r = t[31:0]; c = t[32];
        v = (a[31] != o2[31]) && (r[31] != a[31]);
      end
      4'd4: r = a & o2;
      4'd5: r = a | o2;
      4'd6: r = a ^ o2;
      4'd7: r = a & ~o2;
      4'd8: r = a | ~o2;
      4'd9: r = ~(a ^ o2);
      default: r = '0;
    endcase
    if (sf) model_flags = {r[31], r == 32'd0, v, c};
    it.res = r; it.fl = model_flags; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " result"}, {4'h0, result}, {4'h0, it.res});
        check({it.tag, " flags"}, {32'h0, flags}, {32'h0, it.fl});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10 reset flags", {32'h0, flags}, 36'h0);
    @(negedge clk) rst_n = 1'b1;
    drive("R1 R4 add carry",        4'd0, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001, 13'h0, 8'h00, 0);
    drive("R1 R4 add overflow",     4'd0, 1, 0, 32'h7FFF_FFFF, 32'h0000_0001, 13'h0, 8'h00, 0);
    drive("R4 add neg+neg",         4'd0, 1, 0, 32'h8000_0000, 32'h8000_0000, 13'h0, 8'h00, 0);
    drive("R7 addc narrow cin",     4'd1, 1, 0, 32'h0000_0010, 32'h0000_0020, 13'h0, 8'h01, 0);
    drive("R7 addc wide cin=0",     4'd1, 1, 0, 32'h0000_0010, 32'h0000_0020, 13'h0, 8'h01, 1);
    drive("R7 addc wide cin=1",     4'd1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0000, 13'h0, 8'h10, 1);
    drive("R5 sub borrow",          4'd2, 1, 0, 32'h0000_0001, 32'h0000_0002, 13'h0, 8'h00, 0);
    drive("R5 sub overflow",        4'd2, 1, 0, 32'h8000_0000, 32'h0000_0001, 13'h0, 8'h00, 0);
    drive("R5 sub equal",           4'd2, 1, 0, 32'h1234_5678, 32'h1234_5678, 13'h0, 8'h00, 0);
    drive("R6 subc equal cin",      4'd3, 1, 1, 32'hFFFF_FFFF, 32'h0,         13'h1FFF, 8'h01, 0);
    drive("R6 subc equal wide 0",   4'd3, 1, 0, 32'h0000_0005, 32'h0000_0005, 13'h0, 8'h01, 1);
    drive("R6 subc greater cin",    4'd3, 1, 0, 32'h0000_0006, 32'h0000_0005, 13'h0, 8'h10, 1);
    drive("R3 imm negative",        4'd0, 1, 1, 32'h0000_0010, 32'hDEAD_BEEF, 13'h1FF0, 8'h00, 0);
    drive("R3 imm positive",        4'd5, 1, 1, 32'h0000_0000, 32'hFFFF_FFFF, 13'h0FFF, 8'h00, 0);
    drive("R2 R8 and zero",         4'd4, 1, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 13'h0, 8'hFF, 0);
    drive("R2 R8 or neg",           4'd5, 1, 0, 32'h8000_0000, 32'h0000_0001, 13'h0, 8'hFF, 1);
    drive("R2 xor",                 4'd6, 1, 0, 32'hAAAA_5555, 32'hFFFF_0000, 13'h0, 8'h00, 0);
    drive("R2 andn",                4'd7, 1, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 13'h0, 8'h00, 0);
    drive("R2 orn",                 4'd8, 1, 0, 32'h0000_0000, 32'hFFFF_FFFF, 13'h0, 8'h00, 0);
    drive("R2 xnor",                4'd9, 1, 0, 32'h1234_5678, 32'h1234_5678, 13'h0, 8'h00, 0);
    drive("R4 set before hold",     4'd0, 1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 13'h0, 8'h00, 0);
    drive("R9 hold sub",            4'd2, 0, 0, 32'h0000_0000, 32'h0000_0000, 13'h0, 8'h00, 0);
    drive("R9 hold and",            4'd4, 0, 0, 32'h0000_0000, 32'h0000_0001, 13'h0, 8'hFF, 0);
    drive("R11 reserved 10",        4'd10, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 8'hFF, 0);
    drive("R11 reserved 15",        4'd15, 0, 0, 32'h1234_5678, 32'h1, 13'h0, 8'h00, 0);
    drive("R1 sub wrap",            4'd2, 1, 0, 32'h0000_0000, 32'h0000_0001, 13'h0, 8'h00, 0);
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule